// File: doc/BRIEF.md
# ADC Conversion Handshake Controller

This block runs a parallel-output analog-to-digital converter through its start and busy handshake on behalf of internal logic. When a request arrives while the controller is idle, it drives the active-low read/convert strobe for a fixed minimum number of clock cycles. The converter raises busy for as long as it is working.

The converter's data bus holds garbage, or floats, until the conversion ends. The controller therefore captures nothing until busy has cleared. Busy passes through a two-flop synchroniser. The word is latched on the cycle the synchronised busy is seen low, and it is returned with a single-cycle valid pulse.

Two watchdogs cover a converter that never answers. One fires if busy never rises after the start. The other fires if busy never falls once the conversion is running. Either case ends the transaction with an error pulse and no sample. RISE_TMO must exceed LOW_CYC.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, ready_o=1, adc_rc_no=1, valid_o=0, tmo_rise_o=0 and tmo_fall_o=0.
- R2: A start_i sampled high at a rising edge while ready_o=1 drives adc_rc_no low from that edge for exactly LOW_CYC clock cycles. adc_rc_no then returns high.
- R3: ready_o is 1 only while the controller is idle. start_i is ignored while ready_o=0: it produces no further strobe and no further valid pulse.
- R4: adc_busy_i is synchronised by two flops. valid_o is first seen high after the third rising edge following the edge at which adc_busy_i fell.
- R5: sample_o equals adc_data_i as sampled at the capture edge, never a value from while busy was high. It holds that value until the next capture.
- R6: valid_o is a one-cycle pulse (valid_o=1 implies valid_o=0 on the next cycle), and ready_o is already 1 in the valid cycle.
- R7: If the synchronised busy has not been seen high by RISE_TMO cycles after the accepting edge, tmo_rise_o pulses for one cycle at that edge. No valid pulse follows, and the controller returns to idle. A busy seen exactly on the deadline edge takes priority over the timeout.
- R8: The conversion phase starts at the later of the strobe end and the first edge that acts on the synchronised busy high. If busy has not cleared FALL_TMO cycles after that edge, tmo_fall_o pulses for one cycle instead of valid_o. Busy clearing on the deadline edge wins and produces a capture.
- R9: Busy that rises, and is synchronised, while the strobe is still low is remembered. The conversion phase then starts directly at the end of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, taken only while ready_o is high |
| ready_o | output | 1 | High while idle and able to accept start_i |
| adc_rc_no | output | 1 | Active-low read/convert strobe to the converter |
| adc_busy_i | input | 1 | Converter busy, asynchronous, active high |
| adc_data_i | input | DATA_W | Converter parallel data bus |
| sample_o | output | DATA_W | Last captured conversion result |
| valid_o | output | 1 | One-cycle pulse marking a new sample_o |
| tmo_rise_o | output | 1 | One-cycle pulse: busy never rose in time |
| tmo_fall_o | output | 1 | One-cycle pulse: busy never cleared in time |

## Verification
Each result has a cycle at which it is due, counted from the accepting edge A:
- The strobe falls after edge A and rises after edge A+LOW_CYC.
- valid_o appears after the third edge following the busy fall.
- tmo_rise_o appears after edge A+RISE_TMO.
- tmo_fall_o appears after edge A+max(LOW_CYC, d+3)+FALL_TMO, where d is the converter's rise delay.

The bench counts rising edges and samples every output at the falling edge. It then compares the recorded edge index of each event with these sums, computed from the model settings of each trial. The model sweeps the rise delay and conversion length. Extra trials sit on both sides of each deadline, so that a result one cycle early or late is caught.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_STROBE    = 2'd1,
    ST_WAIT_RISE = 2'd2,
    ST_CONV      = 2'd3
  } conv_state_e;
endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
  parameter int  W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  // saturating phase counter, cleared on phase entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != CntMax)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_capture_reg.sv
module adc_capture_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sample_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] sample_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) sample_q <= data_i;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
  import adc_ctrl_pkg::*;
#(
  parameter int LOW_CYC  = 3,
  parameter int RISE_TMO = 8,
  parameter int FALL_TMO = 12,
  parameter int CNT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             tmr_clr_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             rc_no,
  output logic             tmo_rise_o,
  output logic             tmo_fall_o
);
  localparam logic [CNT_W-1:0] LowLast  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] RiseLast = CNT_W'(RISE_TMO - 1);
  localparam logic [CNT_W-1:0] FallLast = CNT_W'(FALL_TMO - 1);

  conv_state_e state_q, state_d;
  logic        seen_q, rc_q, trise_q, tfall_q;
  logic        rise_err, fall_err;

  always_comb begin
    state_d   = state_q;
    tmr_clr_o = 1'b0;
    capture_o = 1'b0;
    rise_err  = 1'b0;
    fall_err  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_STROBE;
          tmr_clr_o = 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt_i == LowLast) begin
          if (seen_q || busy_s_i) begin
            state_d   = ST_CONV;
            tmr_clr_o = 1'b1;
          end else begin
            state_d = ST_WAIT_RISE;
          end
        end
      end
      ST_WAIT_RISE: begin
        if (busy_s_i) begin
          state_d   = ST_CONV;
          tmr_clr_o = 1'b1;
        end else if (cnt_i == RiseLast) begin
          state_d  = ST_IDLE;
          rise_err = 1'b1;
        end
      end
      ST_CONV: begin
        if (!busy_s_i) begin
          state_d   = ST_IDLE;
          capture_o = 1'b1;
        end else if (cnt_i == FallLast) begin
          state_d  = ST_IDLE;
          fall_err = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
      rc_q    <= 1'b1;
      trise_q <= 1'b0;
      tfall_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rc_q    <= (state_d != ST_STROBE);
      trise_q <= rise_err;
      tfall_q <= fall_err;
      if (state_q != ST_STROBE)  seen_q <= 1'b0;
      else if (busy_s_i)         seen_q <= 1'b1;
    end
  end

  assign ready_o    = (state_q == ST_IDLE);
  assign rc_no      = rc_q;
  assign tmo_rise_o = trise_q;
  assign tmo_fall_o = tfall_q;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int DATA_W   = 12,
  parameter int LOW_CYC  = 3,
  parameter int RISE_TMO = 8,
  parameter int FALL_TMO = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              ready_o,
  output logic              adc_rc_no,
  input  logic              adc_busy_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic [DATA_W-1:0] sample_o,
  output logic              valid_o,
  output logic              tmo_rise_o,
  output logic              tmo_fall_o
);
  localparam int MaxLim = (RISE_TMO > FALL_TMO) ? RISE_TMO : FALL_TMO;
  localparam int CNT_W  = $clog2(MaxLim + 1);

  logic             busy_s;
  logic [CNT_W-1:0] cnt;
  logic             tmr_clr, capture;

  adc_sync2 #(.W(1), .RST_VAL(1'b0)) u_busy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (adc_busy_i),
    .q_o   (busy_s)
  );

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .cnt_o (cnt)
  );

  adc_conv_fsm #(
    .LOW_CYC (LOW_CYC),
    .RISE_TMO(RISE_TMO),
    .FALL_TMO(FALL_TMO),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_s_i  (busy_s),
    .cnt_i     (cnt),
    .tmr_clr_o (tmr_clr),
    .capture_o (capture),
    .ready_o   (ready_o),
    .rc_no     (adc_rc_no),
    .tmo_rise_o(tmo_rise_o),
    .tmo_fall_o(tmo_fall_o)
  );

  adc_capture_reg #(.DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (capture),
    .data_i  (adc_data_i),
    .sample_o(sample_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int LOW_CYC = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ready_o,
  input logic adc_rc_no,
  input logic valid_o,
  input logic tmo_rise_o,
  input logic tmo_fall_o
);
  logic [15:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           low_cnt_q <= '0;
    else if (adc_rc_no)    low_cnt_q <= '0;
    else if (low_cnt_q != 16'hFFFF) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_strobe_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_rc_no) |-> (low_cnt_q == 16'(LOW_CYC)));

  assert_ready_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> adc_rc_no);

  assert_start_only_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_rc_no) |-> $past(ready_o && start_i));

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);

  assert_rise_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_rise_o |-> (!valid_o && !tmo_fall_o && ready_o));

  assert_fall_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_fall_o |-> (!valid_o && ready_o));
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.LOW_CYC(LOW_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ready_o   (ready_o),
  .adc_rc_no (adc_rc_no),
  .valid_o   (valid_o),
  .tmo_rise_o(tmo_rise_o),
  .tmo_fall_o(tmo_fall_o)
);

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb;
  localparam int CLK_P    = 10;
  localparam int DATA_W   = 12;
  localparam int LOW_CYC  = 3;
  localparam int RISE_TMO = 8;
  localparam int FALL_TMO = 12;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              ready_o, adc_rc_no, valid_o, tmo_rise_o, tmo_fall_o;
  logic              adc_busy_i = 1'b0;
  logic [DATA_W-1:0] adc_data_i = '0;
  logic [DATA_W-1:0] sample_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // converter model settings
  int              m_d, m_conv, m_t;
  bit              m_rise_en, m_act;
  logic [DATA_W-1:0] m_word;

  adc_conv_ctrl #(
    .DATA_W(DATA_W), .LOW_CYC(LOW_CYC), .RISE_TMO(RISE_TMO), .FALL_TMO(FALL_TMO)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_o(ready_o),
    .adc_rc_no(adc_rc_no), .adc_busy_i(adc_busy_i), .adc_data_i(adc_data_i),
    .sample_o(sample_o), .valid_o(valid_o), .tmo_rise_o(tmo_rise_o),
    .tmo_fall_o(tmo_fall_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // behavioural converter: busy d edges after strobe seen, high for m_conv edges,
  // word valid one edge before busy falls, junk before that
  always @(posedge clk_i) begin
    #1;
    if (!m_act && !adc_rc_no && rst_ni) begin
      m_act = 1'b1;
      m_t = 0;
      adc_data_i = ~m_word;
    end
    if (m_act) begin
      if (m_rise_en && m_t == m_d) adc_busy_i = 1'b1;
      if (m_t == m_d + m_conv - 1) adc_data_i = m_word;
      if (m_t == m_d + m_conv) adc_busy_i = 1'b0;
      m_t++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 capture, 1 rise timeout, 2 fall timeout
  task automatic run(input int d, input int conv, input bit rise_en,
                     input int hold, input int kind);
    int a, falls, low_cyc, first_low, vcnt, vcyc, vdat, vrdy, rcnt, rcyc, fcnt, fcyc;
    bit prev_low;
    int c_start, exp_c;
    @(negedge clk_i);
    m_act = 1'b0; m_d = d; m_conv = conv; m_rise_en = rise_en;
    m_word = DATA_W'((d * 291 + conv * 77 + 165) & 12'hFFF);
    chk(ready_o === 1'b1, "R3 ready before start", int'(ready_o), 1);
    start_i = 1'b1;
    a = cyc + 1;
    falls = 0; low_cyc = 0; first_low = -1; vcnt = 0; vcyc = -1; vdat = -1; vrdy = 0;
    rcnt = 0; rcyc = -1; fcnt = 0; fcyc = -1; prev_low = 1'b0;
    for (int i = 0; i < 45; i++) begin
      @(negedge clk_i);
      if (i + 1 >= hold) start_i = 1'b0;
      if (!adc_rc_no) begin
        low_cyc++;
        if (!prev_low) begin
          falls++;
          if (falls == 1) first_low = cyc;
        end
      end
      prev_low = !adc_rc_no;
      if (valid_o) begin vcnt++; vcyc = cyc; vdat = int'(sample_o); vrdy = int'(ready_o); end
      if (tmo_rise_o) begin rcnt++; rcyc = cyc; end
      if (tmo_fall_o) begin fcnt++; fcyc = cyc; end
    end
    chk(first_low == a, "R2 strobe start edge", first_low, a);
    chk(low_cyc == LOW_CYC, "R2 strobe width", low_cyc, LOW_CYC);
    chk(falls == 1, "R3 single strobe", falls, 1);
    if (kind == 0) begin
      chk(vcnt == 1, "R3 R6 one valid pulse", vcnt, 1);
      chk(vcyc == a + d + conv + 3, "R4 valid latency", vcyc, a + d + conv + 3);
      chk(vdat == int'(m_word), "R5 captured word", vdat, int'(m_word));
      chk(vrdy == 1, "R6 ready in valid cycle", vrdy, 1);
      chk(int'(sample_o) == int'(m_word), "R5 sample held", int'(sample_o), int'(m_word));
      chk(rcnt + fcnt == 0, "R7 R8 no timeout", rcnt + fcnt, 0);
    end else if (kind == 1) begin
      chk(rcnt == 1 && rcyc == a + RISE_TMO, "R7 rise timeout edge", rcyc, a + RISE_TMO);
      chk(vcnt + fcnt == 0, "R7 no valid after rise timeout", vcnt + fcnt, 0);
    end else begin
      c_start = (LOW_CYC > d + 3) ? LOW_CYC : d + 3;
      exp_c = a + c_start + FALL_TMO;
      chk(fcnt == 1 && fcyc == exp_c, "R8 fall timeout edge", fcyc, exp_c);
      chk(vcnt + rcnt == 0, "R8 no valid after fall timeout", vcnt + rcnt, 0);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_act = 1'b1; m_d = 0; m_conv = 1; m_rise_en = 1'b0; m_word = '0; m_t = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ready_o === 1'b1, "R1 ready", int'(ready_o), 1);
    chk(adc_rc_no === 1'b1, "R1 strobe idle", int'(adc_rc_no), 1);
    chk(valid_o === 1'b0, "R1 valid", int'(valid_o), 0);
    chk(tmo_rise_o === 1'b0 && tmo_fall_o === 1'b0, "R1 timeouts", int'(tmo_rise_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R4 R5 sweep of rise delay and conversion length
    for (int d = 0; d < 4; d++)
      for (int c = 4; c < 8; c++)
        run(d, c, 1'b1, 1, 0);
    // R9 busy seen while strobe low (d=0 syncs before strobe end)
    run(0, 5, 1'b1, 1, 0);
    // R7 boundary: busy seen exactly on deadline edge wins, one later times out
    run(RISE_TMO - 3, 4, 1'b1, 1, 0);
    run(RISE_TMO - 2, 4, 1'b1, 1, 1);
    run(0, 4, 1'b0, 1, 1);
    // R8 boundary: clearing on deadline edge captures, one later times out
    run(0, FALL_TMO, 1'b1, 1, 0);
    run(0, FALL_TMO + 1, 1'b1, 1, 2);
    run(1, FALL_TMO + 4, 1'b1, 1, 2);
    // R3 start held high through the conversion is ignored
    run(0, FALL_TMO, 1'b1, 13, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule